// File: doc/BRIEF.md
# Miss Target List Tracker

This block keeps the waiting requesters of one outstanding cache miss. Targets are added one at a time with a push command, which chooses between two ordered lists. The active list holds the targets that the in-flight downstream request will service. The held-back list holds targets that must wait for a later request. Every target carries three things: a source tag (CPU or snoop), a pending mark and a request id.

When the fill returns, the response type decides which active targets get serviced. A plain read response releases all of them. An invalidating read response releases only the oldest CPU target and every snoop target. The remaining CPU targets stay behind in their original order, and the block raises a flag saying a new downstream request is needed for them. Released targets leave on a valid/ready stream, one per cycle.

A promote command moves the held-back targets to the tail of the active list. A separate command clears every pending mark. Summary flags report whether each list holds a CPU target and whether it holds a pending target.

Top module: `missTargetLists`

## Requirements
- R1: After reset both counts are zero, and `busy`, `drainValid`, `headErr`, `promoteOk`, `reRequest`, `overflow` and all four summary flags are low.
- R2: A push with `pushDefer`=0 appends to the active list and with `pushDefer`=1 to the held-back list, each holding `DEPTH` entries. A push into a full list is dropped, and `overflow` is high for the one cycle after it.
- R3: With `respInval`=0 (plain read response), every active target leaves on the drain stream in list order, and the active list ends empty with `reRequest` low.
- R4: With `respInval`=1 (invalidating response), the drain stream carries the oldest CPU target (`drainSrcSnoop`=0) and every snoop target (`drainSrcSnoop`=1), in their original relative order. The other CPU targets remain in the active list in their original order.
- R5: On an invalidating response whose active list is empty or has a snoop target at its head, `headErr` is high for the one cycle after the response is taken.
- R6: When an invalidating response leaves targets behind, `reRequest` goes high when the drain ends. Any accepted response clears `reRequest`.
- R7: A promote while both lists are empty leaves `promoteOk` low and changes nothing.
- R8: A promote with an empty active list makes the held-back targets the active list in their order. The held-back list is left empty, `promoteOk` pulses for one cycle, and `reRequest` rises.
- R9: A promote with a non-empty active list appends the held-back targets after the existing active ones, in their order.
- R10: `clearPending` clears the pending mark of every target in both lists.
- R11: `primAnyCpu`/`defAnyCpu` are high exactly when the list holds a CPU target. `primAnyPending`/`defAnyPending` are high exactly when the list holds a pending target.
- R12: While `drainValid` is high and `drainReady` is low, the offered target stays unchanged. While `busy` is high, push, promote and clear commands are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pushValid | input | 1 | Add one target |
| pushDefer | input | 1 | 1 selects the held-back list, 0 the active list |
| pushSrcSnoop | input | 1 | Source tag of the pushed target, 1 = snoop, 0 = CPU |
| pushPending | input | 1 | Pending mark of the pushed target |
| pushId | input | 16 | Request id of the pushed target |
| respValid | input | 1 | A read response arrived |
| respInval | input | 1 | 1 = invalidating read response, 0 = plain |
| promoteReq | input | 1 | Move the held-back targets into the active list |
| clearPending | input | 1 | Clear all pending marks |
| drainReady | input | 1 | Consumer accepts the offered target |
| drainValid | output | 1 | A serviceable target is offered |
| drainSrcSnoop | output | 1 | Source tag of the offered target |
| drainPending | output | 1 | Pending mark of the offered target |
| drainId | output | 16 | Request id of the offered target |
| busy | output | 1 | A drain walk is in progress |
| headErr | output | 1 | Invalidating response found no CPU target at the head |
| promoteOk | output | 1 | Pulse: the last promote found a target in some list |
| reRequest | output | 1 | Active targets need a fresh downstream request |
| overflow | output | 1 | Pulse: a target was dropped for lack of space |
| primCount | output | 4 | Targets in the active list |
| defCount | output | 4 | Targets in the held-back list |
| primAnyCpu | output | 1 | Active list holds a CPU target |
| primAnyPending | output | 1 | Active list holds a pending target |
| defAnyCpu | output | 1 | Held-back list holds a CPU target |
| defAnyPending | output | 1 | Held-back list holds a pending target |

## Verification
The properties assume that the consumer can stall the drain stream at any time and that the surrounding logic issues commands only while the block is idle. Apart from that, the stated priority among commands decides what happens.

The stimulus drives exactly one command per idle cycle. It releases backpressure within a few cycles. On purpose, it issues push and promote commands during one drain, so that the block's refusal of them can be seen in the list counts afterwards.

// File: rtl/mtlPkg.sv
package mtlPkg;
  parameter int TGT_ID_W = 16;

  typedef struct packed {
    logic                snoop;
    logic                pending;
    logic [TGT_ID_W-1:0] reqId;
  } tgtEntry_t;

  typedef struct packed {
    logic pushPrim;
    logic pushDef;
    logic popPrim;
    logic rotatePrim;
    logic appendDef;
    logic clrPend;
  } dpStrobe_t;
endpackage

// File: rtl/tgtRing.sv
module tgtRing
  import mtlPkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        pushEn,
  input  tgtEntry_t                   pushEnt,
  input  logic                        popEn,
  input  logic                        rotateEn,
  input  logic                        flushEn,
  input  logic                        appendEn,
  input  tgtEntry_t [DEPTH-1:0]       appendEnts,
  input  logic      [CNT_W-1:0]       appendCnt,
  input  logic                        clrPendEn,
  output tgtEntry_t                   headEnt,
  output logic      [CNT_W-1:0]       count,
  output logic                        full,
  output tgtEntry_t [DEPTH-1:0]       orderedEnts,
  output logic                        anyCpu,
  output logic                        anyPending,
  output logic                        appendDrop
);
  tgtEntry_t ent [DEPTH];
  logic [PTR_W-1:0] headPtr;
  logic [PTR_W-1:0] tailPtr;
  logic [CNT_W-1:0] freeCnt;
  logic [CNT_W-1:0] moveCnt;

  assign tailPtr    = headPtr + count[PTR_W-1:0];
  assign freeCnt    = CNT_W'(DEPTH) - count;
  assign full       = (count == CNT_W'(DEPTH));
  assign moveCnt    = (appendCnt < freeCnt) ? appendCnt : freeCnt;
  assign appendDrop = appendEn && (appendCnt > freeCnt);
  assign headEnt    = ent[headPtr];

  always_comb begin
    anyCpu     = 1'b0;
    anyPending = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      orderedEnts[k] = ent[headPtr + PTR_W'(k)];
      if (CNT_W'(k) < count) begin
        anyCpu     = anyCpu | ~orderedEnts[k].snoop;
        anyPending = anyPending | orderedEnts[k].pending;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr <= '0;
      count   <= '0;
      for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
    end else if (flushEn) begin
      count <= '0;
    end else if (pushEn && !full) begin
      ent[tailPtr] <= pushEnt;
      count        <= count + 1'b1;
    end else if (popEn) begin
      headPtr <= headPtr + 1'b1;
      count   <= count - 1'b1;
    end else if (rotateEn) begin
      ent[tailPtr] <= ent[headPtr];
      headPtr      <= headPtr + 1'b1;
    end else if (appendEn) begin
      for (int k = 0; k < DEPTH; k++) begin
        if (CNT_W'(k) < moveCnt) ent[tailPtr + PTR_W'(k)] <= appendEnts[k];
      end
      count <= count + moveCnt;
    end else if (clrPendEn) begin
      for (int i = 0; i < DEPTH; i++) ent[i].pending <= 1'b0;
    end
  end
endmodule

// File: rtl/targetData.sv
module targetData
  import mtlPkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        stb,
  input  tgtEntry_t        pushEnt,
  output tgtEntry_t        primHead,
  output logic [CNT_W-1:0] primCount,
  output logic [CNT_W-1:0] defCount,
  output logic             primFull,
  output logic             defFull,
  output logic             primAnyCpu,
  output logic             primAnyPending,
  output logic             defAnyCpu,
  output logic             defAnyPending,
  output logic             appendDrop
);
  tgtEntry_t [DEPTH-1:0] defOrdered;
  tgtEntry_t [DEPTH-1:0] primOrdered;
  tgtEntry_t             defHead;
  logic                  defDropUnused;

  tgtRing #(.DEPTH(DEPTH)) u_prim (
    .clk(clk), .rstN(rstN),
    .pushEn(stb.pushPrim), .pushEnt(pushEnt),
    .popEn(stb.popPrim), .rotateEn(stb.rotatePrim),
    .flushEn(1'b0),
    .appendEn(stb.appendDef), .appendEnts(defOrdered), .appendCnt(defCount),
    .clrPendEn(stb.clrPend),
    .headEnt(primHead), .count(primCount), .full(primFull),
    .orderedEnts(primOrdered),
    .anyCpu(primAnyCpu), .anyPending(primAnyPending),
    .appendDrop(appendDrop)
  );

  tgtRing #(.DEPTH(DEPTH)) u_def (
    .clk(clk), .rstN(rstN),
    .pushEn(stb.pushDef), .pushEnt(pushEnt),
    .popEn(1'b0), .rotateEn(1'b0),
    .flushEn(stb.appendDef),
    .appendEn(1'b0), .appendEnts(primOrdered), .appendCnt('0),
    .clrPendEn(stb.clrPend),
    .headEnt(defHead), .count(defCount), .full(defFull),
    .orderedEnts(defOrdered),
    .anyCpu(defAnyCpu), .anyPending(defAnyPending),
    .appendDrop(defDropUnused)
  );
endmodule

// File: rtl/targetCtrl.sv
module targetCtrl
  import mtlPkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushValid,
  input  logic             pushDefer,
  input  logic             respValid,
  input  logic             respInval,
  input  logic             promoteReq,
  input  logic             clearPending,
  input  logic             drainReady,
  input  logic [CNT_W-1:0] primCount,
  input  logic [CNT_W-1:0] defCount,
  input  logic             primFull,
  input  logic             defFull,
  input  logic             primHeadSnoop,
  input  logic             appendDrop,
  output dpStrobe_t        stb,
  output logic             drainValid,
  output logic             busy,
  output logic             headErr,
  output logic             promoteOk,
  output logic             reRequest,
  output logic             overflow
);
  typedef enum logic {ST_IDLE, ST_DRAIN} ctrlState_t;

  ctrlState_t       state;
  logic [CNT_W-1:0] walkLeft;
  logic             invalMode;
  logic             cpuTaken;

  logic idle, acceptResp, acceptProm, acceptClr, acceptPush;
  logic walking, serviceable, anyTargets;

  assign idle        = (state == ST_IDLE);
  assign busy        = ~idle;
  assign acceptResp  = idle && respValid;
  assign acceptProm  = idle && !respValid && promoteReq;
  assign acceptClr   = idle && !respValid && !promoteReq && clearPending;
  assign acceptPush  = idle && !respValid && !promoteReq && !clearPending && pushValid;
  assign walking     = (state == ST_DRAIN) && (walkLeft != '0);
  assign serviceable = !invalMode || primHeadSnoop || !cpuTaken;
  assign drainValid  = walking && serviceable;
  assign anyTargets  = (primCount != '0) || (defCount != '0);

  always_comb begin
    stb            = '0;
    stb.pushPrim   = acceptPush && !pushDefer;
    stb.pushDef    = acceptPush && pushDefer;
    stb.popPrim    = drainValid && drainReady;
    stb.rotatePrim = walking && !serviceable;
    stb.appendDef  = acceptProm && (defCount != '0);
    stb.clrPend    = acceptClr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      walkLeft  <= '0;
      invalMode <= 1'b0;
      cpuTaken  <= 1'b0;
      headErr   <= 1'b0;
      promoteOk <= 1'b0;
      reRequest <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      headErr   <= acceptResp && respInval && ((primCount == '0) || primHeadSnoop);
      promoteOk <= acceptProm && anyTargets;
      overflow  <= (acceptPush && (pushDefer ? defFull : primFull)) ||
                   (stb.appendDef && appendDrop);
      case (state)
        ST_IDLE: begin
          if (acceptResp) begin
            state     <= ST_DRAIN;
            walkLeft  <= primCount;
            invalMode <= respInval;
            cpuTaken  <= 1'b0;
            reRequest <= 1'b0;
          end else if (acceptProm && anyTargets) begin
            reRequest <= 1'b1;
          end
        end
        default: begin
          if (walkLeft == '0) begin
            state <= ST_IDLE;
            if (invalMode && (primCount != '0)) reRequest <= 1'b1;
          end else if (stb.popPrim) begin
            walkLeft <= walkLeft - 1'b1;
            if (!primHeadSnoop) cpuTaken <= 1'b1;
          end else if (stb.rotatePrim) begin
            walkLeft <= walkLeft - 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/missTargetLists.sv
module missTargetLists
  import mtlPkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pushValid,
  input  logic                pushDefer,
  input  logic                pushSrcSnoop,
  input  logic                pushPending,
  input  logic [TGT_ID_W-1:0] pushId,
  input  logic                respValid,
  input  logic                respInval,
  input  logic                promoteReq,
  input  logic                clearPending,
  input  logic                drainReady,
  output logic                drainValid,
  output logic                drainSrcSnoop,
  output logic                drainPending,
  output logic [TGT_ID_W-1:0] drainId,
  output logic                busy,
  output logic                headErr,
  output logic                promoteOk,
  output logic                reRequest,
  output logic                overflow,
  output logic [CNT_W-1:0]    primCount,
  output logic [CNT_W-1:0]    defCount,
  output logic                primAnyCpu,
  output logic                primAnyPending,
  output logic                defAnyCpu,
  output logic                defAnyPending
);
  dpStrobe_t stb;
  tgtEntry_t pushEnt;
  tgtEntry_t primHead;
  logic      primFull, defFull, appendDrop;

  assign pushEnt       = '{snoop: pushSrcSnoop, pending: pushPending, reqId: pushId};
  assign drainSrcSnoop = primHead.snoop;
  assign drainPending  = primHead.pending;
  assign drainId       = primHead.reqId;

  targetCtrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .pushValid(pushValid), .pushDefer(pushDefer),
    .respValid(respValid), .respInval(respInval),
    .promoteReq(promoteReq), .clearPending(clearPending),
    .drainReady(drainReady),
    .primCount(primCount), .defCount(defCount),
    .primFull(primFull), .defFull(defFull),
    .primHeadSnoop(primHead.snoop), .appendDrop(appendDrop),
    .stb(stb), .drainValid(drainValid), .busy(busy),
    .headErr(headErr), .promoteOk(promoteOk),
    .reRequest(reRequest), .overflow(overflow)
  );

  targetData #(.DEPTH(DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .pushEnt(pushEnt),
    .primHead(primHead), .primCount(primCount), .defCount(defCount),
    .primFull(primFull), .defFull(defFull),
    .primAnyCpu(primAnyCpu), .primAnyPending(primAnyPending),
    .defAnyCpu(defAnyCpu), .defAnyPending(defAnyPending),
    .appendDrop(appendDrop)
  );
endmodule

// File: rtl/mtlChecker.sv
module mtlChecker
  import mtlPkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic                clk,
  input logic                rstN,
  input logic                busy,
  input logic                drainValid,
  input logic                drainReady,
  input logic [TGT_ID_W-1:0] drainId,
  input logic [CNT_W-1:0]    primCount,
  input logic [CNT_W-1:0]    defCount,
  input logic                promoteOk,
  input logic                headErr,
  input logic                respValid,
  input logic                respInval
);
  assert_drain_only_busy_R12: assert property (@(posedge clk) disable iff (!rstN)
    drainValid |-> busy);

  assert_drain_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (drainValid && !drainReady) |=> (drainValid && $stable(drainId)));

  assert_defer_frozen_R12: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(defCount));

  assert_promote_empties_R8: assert property (@(posedge clk) disable iff (!rstN)
    promoteOk |-> (defCount == '0));

  assert_head_err_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    headErr |-> $past(respValid && respInval && !busy));

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    (primCount <= CNT_W'(DEPTH)) && (defCount <= CNT_W'(DEPTH)));

  assert_drain_shrinks_R3: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (primCount <= $past(primCount)));
endmodule

bind missTargetLists mtlChecker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy),
  .drainValid(drainValid), .drainReady(drainReady), .drainId(drainId),
  .primCount(primCount), .defCount(defCount),
  .promoteOk(promoteOk), .headErr(headErr),
  .respValid(respValid), .respInval(respInval)
);

// File: tb/missTargetLists_tb.sv
module missTargetLists_tb;
  localparam int DEPTH = 8;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDW   = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pushValid = 0, pushDefer = 0, pushSrcSnoop = 0, pushPending = 0;
  logic [IDW-1:0] pushId = '0;
  logic respValid = 0, respInval = 0, promoteReq = 0, clearPending = 0;
  logic drainReady = 1'b1;
  logic drainValid, drainSrcSnoop, drainPending, busy, headErr, promoteOk;
  logic reRequest, overflow, primAnyCpu, primAnyPending, defAnyCpu, defAnyPending;
  logic [IDW-1:0] drainId;
  logic [CNT_W-1:0] primCount, defCount;

  int total = 0;
  int bad = 0;
  logic modelReReq = 1'b0;

  // entry = {snoop, pending, id}
  logic [IDW+1:0] primQ[$];
  logic [IDW+1:0] defQ[$];
  logic [IDW+1:0] expQ[$];

  always #5 clk = ~clk;

  missTargetLists #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN),
    .pushValid(pushValid), .pushDefer(pushDefer), .pushSrcSnoop(pushSrcSnoop),
    .pushPending(pushPending), .pushId(pushId),
    .respValid(respValid), .respInval(respInval),
    .promoteReq(promoteReq), .clearPending(clearPending),
    .drainReady(drainReady), .drainValid(drainValid),
    .drainSrcSnoop(drainSrcSnoop), .drainPending(drainPending), .drainId(drainId),
    .busy(busy), .headErr(headErr), .promoteOk(promoteOk),
    .reRequest(reRequest), .overflow(overflow),
    .primCount(primCount), .defCount(defCount),
    .primAnyCpu(primAnyCpu), .primAnyPending(primAnyPending),
    .defAnyCpu(defAnyCpu), .defAnyPending(defAnyPending)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic anyCpuOf(input logic [IDW+1:0] q[$]);
    foreach (q[i]) if (!q[i][IDW+1]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic anyPendOf(input logic [IDW+1:0] q[$]);
    foreach (q[i]) if (q[i][IDW]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic checkState(input string req);
    check(primCount == CNT_W'(primQ.size()), {req, " primCount"}, primCount, primQ.size());
    check(defCount == CNT_W'(defQ.size()), {req, " defCount"}, defCount, defQ.size());
    check(reRequest == modelReReq, {req, " reRequest (R6)"}, reRequest, modelReReq);
    check(primAnyCpu == anyCpuOf(primQ), "R11 primAnyCpu", primAnyCpu, anyCpuOf(primQ));
    check(primAnyPending == anyPendOf(primQ), "R11 primAnyPending", primAnyPending, anyPendOf(primQ));
    check(defAnyCpu == anyCpuOf(defQ), "R11 defAnyCpu", defAnyCpu, anyCpuOf(defQ));
    check(defAnyPending == anyPendOf(defQ), "R11 defAnyPending", defAnyPending, anyPendOf(defQ));
  endtask

  task automatic doPush(input logic defer, input logic snp, input logic pend, input int id);
    bit wasFull;
    wasFull = defer ? (defQ.size() == DEPTH) : (primQ.size() == DEPTH);
    @(negedge clk);
    pushValid = 1; pushDefer = defer; pushSrcSnoop = snp; pushPending = pend; pushId = IDW'(id);
    @(negedge clk);
    pushValid = 0;
    if (!wasFull) begin
      if (defer) defQ.push_back({snp, pend, IDW'(id)});
      else primQ.push_back({snp, pend, IDW'(id)});
    end
    check(overflow == wasFull, "R2 overflow pulse", overflow, wasFull);
  endtask

  task automatic doResp(input logic inval, input int stallCycles);
    logic [IDW+1:0] keep[$];
    bit taken;
    bit expErr;
    int guard;
    keep = {};
    taken = 0;
    expErr = inval && (primQ.size() == 0 || primQ[0][IDW+1]);
    foreach (primQ[i]) begin
      if (!inval || primQ[i][IDW+1] || !taken) begin
        expQ.push_back(primQ[i]);
        if (!primQ[i][IDW+1]) taken = 1;
      end else keep.push_back(primQ[i]);
    end
    primQ = keep;
    modelReReq = inval && (keep.size() != 0);
    if (stallCycles > 0) begin
      @(posedge clk); #1 drainReady = 0;
    end
    @(negedge clk);
    respValid = 1; respInval = inval;
    @(negedge clk);
    respValid = 0;
    check(headErr == expErr, "R5 headErr", headErr, expErr);
    if (stallCycles > 0) begin
      repeat (stallCycles) @(posedge clk);
      #1 drainReady = 1;
    end
    guard = 0;
    while (busy && guard < 100) begin @(negedge clk); guard++; end
    check(expQ.size() == 0, "R3/R4 drained items outstanding", expQ.size(), 0);
    expQ = {};
  endtask

  task automatic doPromote();
    bit expOk;
    expOk = (primQ.size() != 0) || (defQ.size() != 0);
    @(negedge clk);
    promoteReq = 1;
    @(negedge clk);
    promoteReq = 0;
    foreach (defQ[i]) if (primQ.size() < DEPTH) primQ.push_back(defQ[i]);
    defQ = {};
    if (expOk) modelReReq = 1;
    check(promoteOk == expOk, "R7/R8 promoteOk", promoteOk, expOk);
  endtask

  task automatic doClear();
    @(negedge clk);
    clearPending = 1;
    @(negedge clk);
    clearPending = 0;
    foreach (primQ[i]) primQ[i][IDW] = 1'b0;
    foreach (defQ[i]) defQ[i][IDW] = 1'b0;
  endtask

  // scoreboard monitor
  bit holdPend = 0;
  logic [IDW-1:0] holdId;
  always @(negedge clk) begin
    if (rstN) begin
      if (holdPend)
        check(drainValid && drainId == holdId, "R12 stalled target held", drainId, holdId);
      holdPend = drainValid && !drainReady;
      holdId = drainId;
      if (drainValid && drainReady) begin
        if (expQ.size() == 0) check(0, "R3/R4 unexpected drain item", drainId, -1);
        else begin
          logic [IDW+1:0] e;
          e = expQ.pop_front();
          check({drainSrcSnoop, drainPending, drainId} == e, "R3/R4/R10 drain item",
                int'({drainSrcSnoop, drainPending, drainId}), int'(e));
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !drainValid && !headErr && !promoteOk && !overflow, "R1 control outputs", 1, 0);
    checkState("R1");

    // R4 / R6: invalidating response keeps later CPU targets
    doPush(0, 0, 1, 1);
    doPush(0, 1, 0, 2);
    doPush(0, 0, 0, 3);
    doPush(0, 1, 1, 4);
    doPush(0, 0, 0, 5);
    checkState("R2 after pushes");
    doResp(1, 0);
    checkState("R4 after invalidating drain");

    // R9: promote appends behind non-empty active list
    doPush(1, 0, 1, 10);
    doPush(1, 1, 0, 11);
    checkState("R2 deferred pushes");
    doPromote();
    checkState("R9 after append");

    // R10 clear then R3 plain drain with backpressure (R12)
    doClear();
    checkState("R10 after clear");
    doResp(0, 3);
    checkState("R3 after plain drain");

    // R7 promote with nothing queued
    doPromote();
    checkState("R7 empty promote");

    // R8 promote into empty list, then R5 snoop at head
    doPush(1, 1, 0, 20);
    doPush(1, 0, 1, 21);
    doPromote();
    checkState("R8 after move");
    doResp(1, 0);
    checkState("R5 after snoop-head drain");

    // R2 overflow on full active list
    for (int i = 0; i < DEPTH + 1; i++) doPush(0, i[0], 0, 30 + i);
    checkState("R2 full list");

    // R12 commands ignored while busy
    begin
      logic [IDW+1:0] keep2[$];
      foreach (primQ[i]) expQ.push_back(primQ[i]);
      primQ = {};
      modelReReq = 0;
      @(negedge clk);
      respValid = 1; respInval = 0;
      @(negedge clk);
      respValid = 0;
      pushValid = 1; pushDefer = 1; pushSrcSnoop = 0; pushId = 16'h77;
      @(negedge clk);
      pushValid = 0; promoteReq = 1;
      @(negedge clk);
      promoteReq = 0;
      while (busy) @(negedge clk);
      check(expQ.size() == 0, "R12 drain complete", expQ.size(), 0);
      keep2 = {};
      checkState("R12 busy-ignored commands");
    end

    // R5 invalidating response on empty list
    doResp(1, 0);
    checkState("R5 empty list");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule